// File: doc/BRIEF.md
# Period-Match Timer with Postscaled Interrupt

This block is an 8-bit interval timer driven by a one-cycle tick enable that runs at one quarter of the system oscillator rate. A prescaler divides the ticks by 1, 4 or 16. Each prescaled step either advances the counter or, if the counter already equals the period register, returns it to zero. A return to zero raises an unscaled match pulse for one clock. Other logic can use that pulse as a PWM time base or as a serial shift clock.

A 4-bit postscaler counts match events and fires once every 1 to 16 matches. Each firing sets a sticky interrupt flag. The interrupt request output is the flag gated by an enable bit. A small register port gives software read and write access to the counter, period, control and status registers. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `period_match_timer`

## Requirements
- R1: After reset the counter reads 0x00, period 0xFF, control 0x00 and status 0x00. The match pulse and interrupt request are both low.
- R2: The prescale select in control bits 1:0 sets how many ticks make one counter step: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R3: A step taken while the counter equals the period returns the counter to 0x00. Any other step adds one. The step that returns the counter to zero drives match_pulse high for the following clock. With ratio N and period P, matches therefore recur every N*(P+1) ticks.
- R4: The postscale select in control bits 6:3, value S, sets the status flag once per S+1 match events.
- R5: The flag is status bit 0. It stays set until a status write with bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged. A set and a clear in the same clock leave the flag set.
- R6: irq is high exactly when the flag and the interrupt enable (status bit 1) are both set.
- R7: While the run bit (control bit 2) is 0, the counter keeps its value, and no match pulse and no flag set occur.
- R8: A write to the counter or to control discards the prescaler and postscaler progress and suppresses a step in that clock. Such a write leaves the period register unchanged.
- R9: Register addresses are 0 counter, 1 period, 2 control, 3 status. Control bit 7 and status bits 7:2 read as 0. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the instruction rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| match_pulse | output | 1 | Unscaled one-clock match pulse |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples the strobe. A step, a match pulse, a flag set and the resulting irq all appear after the edge that samples the final tick needed. None of these results has an extra pipeline stage. The bench counts edges from the first tick of each scenario and compares the edge on which match_pulse and the flag first appear against N*(P+1) and N*(P+1)*(S+1). All outputs and read data are sampled on the falling edge. Stimulus changes only on falling edges, so every sample lands between the edge that caused it and the next one.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_COUNT  = 2'd0,
    A_PERIOD = 2'd1,
    A_CTRL   = 2'd2,
    A_STATUS = 2'd3
  } reg_sel_e;

  // control register bits 6:0; bit 7 reads as zero
  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_EN_BIT   = 1;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       step
);
  localparam logic [PRE_W-1:0] TERM_MID = PRE_W'((1 << (PRE_W/2)) - 1);
  localparam logic [PRE_W-1:0] TERM_MAX = PRE_W'((1 << PRE_W) - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] term;

  always_comb begin
    case (sel)
      2'b00:   term = '0;
      2'b01:   term = TERM_MID;
      default: term = TERM_MAX;
    endcase
  end

  assign step = tick && run && !clr && (pre_cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)        pre_cnt <= '0;
    else if (tick && run)     pre_cnt <= (pre_cnt == term) ? '0 : pre_cnt + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= term); // R2
endmodule

// File: rtl/pmt_period_core.sv
module pmt_period_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         match_evt,
  output logic         match_q
);
  assign match_evt = step && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (match_evt)  cnt <= '0;
    else if (step)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_evt && !ld;
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && cnt != period) |=> (cnt == $past(cnt) + 1'b1)); // R3
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);
  logic [SEL_W-1:0] post_cnt;

  assign fire = evt && (post_cnt == sel);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  post_cnt <= '0;
    else if (evt)       post_cnt <= fire ? '0 : post_cnt + 1'b1;
  end

  AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    post_cnt <= sel); // R4
endmodule

// File: rtl/period_match_timer.sv
module period_match_timer
  import pmt_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              match_pulse,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  reg_sel_e          sel;
  logic              wr_count, wr_period, wr_ctrl, wr_status, restart;
  logic [DATA_W-1:0] period_q, cnt;
  ctrl_t             ctrl_q;
  logic              flag_q, en_q, flag_clr;
  logic              step, match_evt, fire;

  assign sel       = reg_sel_e'(bus_addr);
  assign wr_count  = bus_wr && (sel == A_COUNT);
  assign wr_period = bus_wr && (sel == A_PERIOD);
  assign wr_ctrl   = bus_wr && (sel == A_CTRL);
  assign wr_status = bus_wr && (sel == A_STATUS);
  assign restart   = wr_count || wr_ctrl;
  assign flag_clr  = wr_status && !bus_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '1;
      ctrl_q   <= '0;
      en_q     <= 1'b0;
    end else begin
      if (wr_period) period_q <= bus_wdata;
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_status) en_q     <= bus_wdata[STAT_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (fire)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  pmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick),
    .run(ctrl_q.run), .sel(ctrl_q.pre_sel), .step(step)
  );

  pmt_period_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .ld(wr_count),
    .ld_val(bus_wdata), .period(period_q), .cnt(cnt),
    .match_evt(match_evt), .match_q(match_pulse)
  );

  pmt_postscaler #(.SEL_W(4)) u_post (
    .clk(clk), .rst_n(rst_n), .clr(restart), .evt(match_evt),
    .sel(ctrl_q.post_sel), .fire(fire)
  );

  assign irq = flag_q && en_q;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      A_COUNT:  bus_rdata = cnt;
      A_PERIOD: bus_rdata = period_q;
      A_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_STATUS: begin
        bus_rdata[STAT_FLAG_BIT] = flag_q;
        bus_rdata[STAT_EN_BIT]   = en_q;
      end
      default:  bus_rdata = '0;
    endcase
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (cnt == '0)); // R3
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_evt)); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_count) |=> ($stable(cnt) && !match_pulse)); // R7
endmodule

// File: tb/test_period_match_timer.sv
`timescale 1ns/1ps
module test_period_match_timer;
  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic match_pulse, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  period_match_timer i_period_match_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_pulse(match_pulse), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  pre;
    logic [3:0]  post;
    logic [7:0]  per;
    logic [15:0] m_edge;
    logic [15:0] f_edge;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 4'd0,  8'd5, 16'd6,  16'd6},
    '{2'b01, 4'd2,  8'd3, 16'd16, 16'd48},
    '{2'b10, 4'd1,  8'd0, 16'd16, 16'd32},
    '{2'b11, 4'd15, 8'd2, 16'd48, 16'd768},
    '{2'b00, 4'd15, 8'd0, 16'd1,  16'd16},
    '{2'b01, 4'd0,  8'd9, 16'd40, 16'd40}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic run_ticks(int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  function automatic logic [7:0] ctrl(logic [3:0] post, logic run, logic [1:0] pre);
    return {1'b0, post, run, pre};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R9 map
    rd_reg(2'd0, v); check("R1 count", v, 8'h00);
    rd_reg(2'd1, v); check("R1 period", v, 8'hFF);
    rd_reg(2'd2, v); check("R1 ctrl", v, 8'h00);
    rd_reg(2'd3, v); check("R1 status", v, 8'h00);
    check("R1 match", match_pulse, 0);
    check("R1 irq", irq, 0);

    // vector table: R2, R3, R4
    foreach (VECS[i]) begin
      int first_m, first_f, n_m;
      wr_reg(2'd1, VECS[i].per);
      wr_reg(2'd0, 8'd0);
      wr_reg(2'd3, 8'h02);
      wr_reg(2'd2, ctrl(VECS[i].post, 1'b1, VECS[i].pre));
      bus_addr = 2'd3;
      first_m = 0; first_f = 0; n_m = 0;
      tick = 1;
      for (int n = 1; n <= int'(VECS[i].f_edge) + 2; n++) begin
        @(negedge clk);
        if (match_pulse && n <= int'(VECS[i].f_edge)) n_m++;
        if (match_pulse && first_m == 0) first_m = n;
        if (bus_rdata[0] && first_f == 0) first_f = n;
      end
      tick = 0;
      check("R2 R3 first match edge", first_m, VECS[i].m_edge);
      check("R4 first flag edge", first_f, VECS[i].f_edge);
      check("R3 match count", n_m, VECS[i].post + 1);
      check("R6 irq with enable", irq, 1);
    end

    // R9 readback, control bit 7 and status spare bits
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h5A);
    rd_reg(2'd0, v); check("R9 count readback", v, 8'h5A);
    wr_reg(2'd1, 8'h33);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); check("R9 ctrl bit7 zero", v, 8'h7F);
    rd_reg(2'd1, v); check("R8 period kept", v, 8'h33);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'hFD);
    rd_reg(2'd3, v); check("R5 write 1 no set", v, 8'h00);

    // R7 timer off holds
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd0, 8'h10);
    begin
      int seen = 0;
      tick = 1;
      repeat (30) begin @(negedge clk); if (match_pulse) seen++; end
      tick = 0;
      check("R7 no match when off", seen, 0);
    end
    rd_reg(2'd0, v); check("R7 count held", v, 8'h10);
    rd_reg(2'd3, v); check("R7 no flag when off", v, 8'h00);

    // R8 prescaler progress discarded by control write
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, ctrl(4'd0, 1'b1, 2'b01));
    run_ticks(2);
    wr_reg(2'd2, ctrl(4'd0, 1'b1, 2'b01));
    run_ticks(3);
    rd_reg(2'd0, v); check("R8 prescale restart", v, 8'h00);
    run_ticks(1);
    rd_reg(2'd0, v); check("R2 step after 4", v, 8'h01);

    // R8 postscaler progress discarded by counter write
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, ctrl(4'd1, 1'b1, 2'b00));
    wr_reg(2'd3, 8'h00);
    run_ticks(1);
    wr_reg(2'd0, 8'h00);
    run_ticks(1);
    rd_reg(2'd3, v); check("R8 postscale restart", v, 8'h00);
    run_ticks(1);
    rd_reg(2'd3, v); check("R4 flag after 2", v[0], 1);

    // R5 set beats clear, R6 gating
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, ctrl(4'd0, 1'b1, 2'b00));
    tick = 1;
    repeat (2) @(negedge clk);
    bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wr = 0; tick = 0;
    rd_reg(2'd3, v); check("R5 set wins", v, 8'h01);
    check("R6 irq gated off", irq, 0);
    wr_reg(2'd3, 8'h03);
    check("R6 irq on", irq, 1);
    wr_reg(2'd3, 8'h02);
    rd_reg(2'd3, v); check("R5 clear by 0", v, 8'h02);
    check("R6 irq after clear", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule